// File: doc/BRIEF.md
# Coprocessor transfer handshake sequencer

This block sits on the coprocessor side of a coprocessor load/store exchange with a processor core. The core announces that a transfer instruction has entered the coprocessor's execute stage. With that announcement come the direction (load into the coprocessor, or store out of it), the coprocessor number, the number of words to move and a busy-wait length. The block then answers every cycle with a 2-bit handshake code. The code tells the core to hold off, to keep transferring, or that the next word is the final one. When no instruction of its own is in progress, the code tells the core that nobody is there.

Loads write the inbound words into a 16-entry internal buffer at consecutive indices and raise a one-cycle completion pulse. Stores read the same buffer in the same order onto the outbound data bus. The block keeps ownership of that bus until the next instruction arrives, even when the store itself is dropped. The core's pass and cancel indications are sampled with the announcement, and a dropped instruction leaves no trace. The sequencer runs on the free-running clock. A core stall freezes word movement, but busy-waiting keeps counting down during a stall.

Top module: `cp_xfer_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the handshake code is 2'b10 (none), `st_own` is 0 and `ld_done` is 0.
- R2: With no transfer in progress, the handshake code is 2'b10. An announcement whose `cp_sel` differs from the block's coprocessor number starts nothing, and the code stays 2'b10.
- R3: After an accepted announcement, the code is 2'b00 (hold) for exactly `busy_cycles` cycles, starting in the cycle after the announcement. Core stalls do not lengthen this count.
- R4: Once holding ends, the code is 2'b01 (more) while two or more words remain and 2'b11 (final) while exactly one remains. A transfer of N words therefore shows N-1 codes of 2'b01 and then one 2'b11, and after that the code returns to 2'b10. A one-word transfer shows no 2'b01.
- R5: A `xfer_words` value of 0 moves one word, and a value above 16 moves 16 words.
- R6: A 2'b01 or 2'b11 cycle with `core_stall` high moves no word, and the code stays the same in the next cycle. Each such cycle with `core_stall` low moves exactly one word.
- R7: An announcement with `cp_pass` low or `cp_cancel` high is dropped. The code is 2'b10 in the next cycle, the buffer is not written and `ld_done` stays low.
- R8: `st_own` becomes 1 in the cycle after a store announcement for this block's number, whether or not it is dropped. It becomes 0 in the cycle after any announcement that is not such a store.
- R9: During a load, the word on `ld_data` in the k-th (counting from 0) non-stalled 2'b01/2'b11 cycle is written to buffer index k.
- R10: During a store, in every 2'b01/2'b11 cycle of the k-th word, `st_data` shows buffer entry k.
- R11: `ld_done` is high for exactly one cycle, the cycle after the non-stalled 2'b11 cycle of an accepted load, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| cp_issue | input | 1 | A transfer instruction enters execute this cycle |
| cp_is_load | input | 1 | 1 = load into the coprocessor, 0 = store out of it |
| cp_sel | input | 4 | Coprocessor number targeted by the instruction |
| cp_pass | input | 1 | Instruction condition passed (sampled with cp_issue) |
| cp_cancel | input | 1 | Late cancel of the instruction (sampled with cp_issue) |
| core_stall | input | 1 | Core pipeline stalled; no word moves this cycle |
| busy_cycles | input | 4 | Hold cycles before the transfer starts (0 to 15) |
| xfer_words | input | 5 | Words to move (0 is taken as 1, above 16 as 16) |
| ld_data | input | 32 | Inbound word during loads |
| hs_code | output | 2 | Handshake code: 10 none, 00 hold, 01 more, 11 final |
| st_data | output | 32 | Outbound word during stores |
| st_own | output | 1 | Block owns the outbound data bus |
| ld_done | output | 1 | One-cycle pulse after the last load word |

## Verification
The bench builds the block with its defaults: a 16-entry buffer, a 4-bit busy-wait count and coprocessor number 7. These values make a full 16-word burst, the longest 15-cycle hold and the index wrap from 15 back to 0 reachable in short runs. Word counts from 0 to 19 reach both clamping edges. A cycle-level model tracks the handshake, ownership, completion pulse and buffer contents, so a store that follows a load, or a dropped load, shows whether each buffer write happened. Random stalls fall both in hold cycles and in transfer cycles, which separates the freeze rule from the hold count.

// File: rtl/cp_xfer_pkg.sv
package cp_xfer_pkg;
  typedef enum logic [1:0] {
    HS_HOLD  = 2'b00,
    HS_MORE  = 2'b01,
    HS_NONE  = 2'b10,
    HS_FINAL = 2'b11
  } hs_code_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_MOVE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/cp_hs_fsm.sv
module cp_hs_fsm
  import cp_xfer_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WAIT_W = 4,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_load,
  input  logic [WAIT_W-1:0] wait_len,
  input  logic [CNT_W-1:0]  word_cnt,
  input  logic              stall,
  output hs_code_t          hs,
  output logic              idle,
  output logic              move,
  output logic              last_move,
  output logic              load_mode,
  output logic [IDX_W-1:0]  idx,
  output logic [IDX_W-1:0]  rd_idx
);
  seq_state_t        state_q, state_d;
  logic [CNT_W-1:0]  rem_q, rem_d, cnt_eff;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  hs_code_t          hs_q, hs_d;
  logic              load_q;

  // clamp the requested word count into 1..DEPTH
  always_comb begin
    if (word_cnt == '0)
      cnt_eff = CNT_W'(1);
    else if (word_cnt > CNT_W'(DEPTH))
      cnt_eff = CNT_W'(DEPTH);
    else
      cnt_eff = word_cnt;
  end

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    wait_d  = wait_q;
    idx_d   = idx_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          rem_d   = cnt_eff;
          idx_d   = '0;
          wait_d  = wait_len;
          state_d = (wait_len != '0) ? ST_WAIT : ST_MOVE;
        end
      end
      ST_WAIT: begin
        // hold countdown runs on the free clock, stall does not matter
        wait_d = wait_q - WAIT_W'(1);
        if (wait_q == WAIT_W'(1)) state_d = ST_MOVE;
      end
      ST_MOVE: begin
        if (!stall) begin
          idx_d = idx_q + IDX_W'(1);
          rem_d = rem_q - CNT_W'(1);
          if (rem_q == CNT_W'(1)) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registered handshake code is derived from the next state
  always_comb begin
    case (state_d)
      ST_WAIT: hs_d = HS_HOLD;
      ST_MOVE: hs_d = (rem_d == CNT_W'(1)) ? HS_FINAL : HS_MORE;
      default: hs_d = HS_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      hs_q    <= HS_NONE;
      rem_q   <= '0;
      wait_q  <= '0;
      idx_q   <= '0;
      load_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hs_q    <= hs_d;
      rem_q   <= rem_d;
      wait_q  <= wait_d;
      idx_q   <= idx_d;
      if (state_q == ST_IDLE && start) load_q <= start_load;
    end
  end

  assign hs        = hs_q;
  assign idle      = (state_q == ST_IDLE);
  assign move      = (state_q == ST_MOVE) && !stall;
  assign last_move = move && (rem_q == CNT_W'(1));
  assign load_mode = load_q;
  assign idx       = idx_q;
  assign rd_idx    = idx_d;
endmodule

// File: rtl/cp_word_buf.sv
module cp_word_buf #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  // one write port, one registered read port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/cp_xfer_seq.sv
module cp_xfer_seq
  import cp_xfer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WAIT_W = 4,
  parameter int unsigned CPN_W  = 4,
  parameter logic [CPN_W-1:0] CP_ID = CPN_W'(7),
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cp_issue,
  input  logic              cp_is_load,
  input  logic [CPN_W-1:0]  cp_sel,
  input  logic              cp_pass,
  input  logic              cp_cancel,
  input  logic              core_stall,
  input  logic [WAIT_W-1:0] busy_cycles,
  input  logic [CNT_W-1:0]  xfer_words,
  input  logic [DATA_W-1:0] ld_data,
  output logic [1:0]        hs_code,
  output logic [DATA_W-1:0] st_data,
  output logic              st_own,
  output logic              ld_done
);
  hs_code_t         hs;
  logic             idle, move, last_move, load_mode, start, mine;
  logic [IDX_W-1:0] idx, rd_idx;
  logic             own_q, done_q;

  assign mine  = (cp_sel == CP_ID);
  assign start = cp_issue && idle && mine && cp_pass && !cp_cancel;

  cp_hs_fsm #(
    .DEPTH (DEPTH),
    .WAIT_W(WAIT_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_load(cp_is_load),
    .wait_len  (busy_cycles),
    .word_cnt  (xfer_words),
    .stall     (core_stall),
    .hs        (hs),
    .idle      (idle),
    .move      (move),
    .last_move (last_move),
    .load_mode (load_mode),
    .idx       (idx),
    .rd_idx    (rd_idx)
  );

  cp_word_buf #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) u_buf (
    .clk  (clk),
    .we   (move && load_mode),
    .waddr(idx),
    .wdata(ld_data),
    .raddr(rd_idx),
    .rdata(st_data)
  );

  // bus ownership follows every announcement, dropped or not
  always_ff @(posedge clk) begin
    if (rst) begin
      own_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (cp_issue) own_q <= mine && !cp_is_load;
      done_q <= last_move && load_mode;
    end
  end

  assign hs_code = hs;
  assign st_own  = own_q;
  assign ld_done = done_q;
endmodule

// File: rtl/cp_xfer_seq_chk.sv
module cp_xfer_seq_chk #(
  parameter int unsigned CPN_W = 4,
  parameter logic [CPN_W-1:0] CP_ID = CPN_W'(7),
  parameter int unsigned WAIT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cp_issue,
  input logic              cp_is_load,
  input logic [CPN_W-1:0]  cp_sel,
  input logic              cp_pass,
  input logic              cp_cancel,
  input logic              core_stall,
  input logic [WAIT_W-1:0] busy_cycles,
  input logic [1:0]        hs_code,
  input logic              st_own,
  input logic              ld_done
);
  localparam logic [1:0] C_HOLD  = 2'b00;
  localparam logic [1:0] C_MORE  = 2'b01;
  localparam logic [1:0] C_NONE  = 2'b10;
  localparam logic [1:0] C_FINAL = 2'b11;

  // R2
  foreign_cp_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_issue && hs_code == C_NONE && cp_sel != CP_ID) |=> hs_code == C_NONE);

  // R3
  hold_first_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_issue && hs_code == C_NONE && cp_sel == CP_ID && cp_pass && !cp_cancel
     && busy_cycles != '0) |=> hs_code == C_HOLD);

  // R4
  final_then_none_chk: assert property (@(posedge clk) disable iff (rst)
    (hs_code == C_FINAL && !core_stall) |=> hs_code == C_NONE);

  // R6
  stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    ((hs_code == C_MORE || hs_code == C_FINAL) && core_stall) |=> hs_code == $past(hs_code));

  // R7
  dropped_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_issue && hs_code == C_NONE && (!cp_pass || cp_cancel)) |=> hs_code == C_NONE);

  // R8
  store_own_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_issue && cp_sel == CP_ID && !cp_is_load) |=> st_own);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    ld_done |=> !ld_done);

  // R11
  done_after_final_chk: assert property (@(posedge clk) disable iff (rst)
    ld_done |-> ($past(hs_code) == C_FINAL && !$past(core_stall)));
endmodule

bind cp_xfer_seq cp_xfer_seq_chk #(
  .CPN_W (CPN_W),
  .CP_ID (CP_ID),
  .WAIT_W(WAIT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cp_issue   (cp_issue),
  .cp_is_load (cp_is_load),
  .cp_sel     (cp_sel),
  .cp_pass    (cp_pass),
  .cp_cancel  (cp_cancel),
  .core_stall (core_stall),
  .busy_cycles(busy_cycles),
  .hs_code    (hs_code),
  .st_own     (st_own),
  .ld_done    (ld_done)
);

// File: tb/cp_xfer_seq_tb.sv
`timescale 1ns/1ps
module cp_xfer_seq_tb;
  localparam int DEPTH = 16;
  localparam logic [3:0] MY_CP = 4'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cp_issue = 1'b0, cp_is_load = 1'b0, cp_pass = 1'b1, cp_cancel = 1'b0;
  logic [3:0]  cp_sel = MY_CP;
  logic        core_stall = 1'b0;
  logic [3:0]  busy_cycles = '0;
  logic [4:0]  xfer_words = '0;
  logic [31:0] ld_data = '0;
  logic [1:0]  hs_code;
  logic [31:0] st_data;
  logic        st_own, ld_done;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  cp_xfer_seq u_dut (
    .clk(clk), .rst(rst), .cp_issue(cp_issue), .cp_is_load(cp_is_load),
    .cp_sel(cp_sel), .cp_pass(cp_pass), .cp_cancel(cp_cancel),
    .core_stall(core_stall), .busy_cycles(busy_cycles), .xfer_words(xfer_words),
    .ld_data(ld_data), .hs_code(hs_code), .st_data(st_data),
    .st_own(st_own), .ld_done(ld_done)
  );

  // reference model state
  int          m_st = 0, m_rem = 0, m_wait = 0, m_idx = 0;
  bit          m_ld = 0, m_oe = 0, m_done = 0;
  logic [31:0] mem_m [DEPTH];
  bit          known [DEPTH];
  string       none_tag = "R2";
  string       move_tag = "R4";
  string       data_tag = "R10";

  function automatic int words_for(int n);
    if (n == 0) return 1;
    if (n > DEPTH) return DEPTH;
    return n;
  endfunction

  function automatic logic [1:0] exp_hs();
    if (m_st == 1) return 2'b00;
    if (m_st == 2) return (m_rem == 1) ? 2'b11 : 2'b01;
    return 2'b10;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cycle();
    bit nd;
    logic [1:0] e;
    string t;
    @(posedge clk);
    nd = 0;
    if (cp_issue) m_oe = (cp_sel == MY_CP) && !cp_is_load;
    case (m_st)
      0: if (cp_issue && cp_sel == MY_CP && cp_pass && !cp_cancel) begin
           m_rem = words_for(int'(xfer_words)); m_idx = 0;
           m_wait = int'(busy_cycles); m_ld = cp_is_load;
           m_st = (m_wait != 0) ? 1 : 2;
         end
      1: begin m_wait--; if (m_wait == 0) m_st = 2; end
      default: if (!core_stall) begin
           if (m_ld) begin mem_m[m_idx] = ld_data; known[m_idx] = 1; end
           m_idx = (m_idx + 1) % DEPTH; m_rem--;
           if (m_rem == 0) begin m_st = 0; nd = m_ld; end
         end
    endcase
    m_done = nd;
    @(negedge clk);
    e = exp_hs();
    t = (e == 2'b10) ? none_tag : (e == 2'b00) ? "R3" : move_tag;
    chk(hs_code == e, t, "hs_code", hs_code, e);
    chk(st_own == m_oe, "R8", "st_own", st_own, m_oe);
    chk(ld_done == m_done, "R11", "ld_done", ld_done, m_done);
    if (m_st == 2 && !m_ld && known[m_idx])
      chk(st_data == mem_m[m_idx], data_tag, "st_data", st_data, mem_m[m_idx]);
  endtask

  task automatic xact(bit ld, logic [3:0] cp, int w, int n, bit ps, bit lc, int stall_pct);
    int moved = 0;
    bit acc;
    acc = (cp == MY_CP) && ps && !lc;
    cp_issue = 1; cp_is_load = ld; cp_sel = cp; cp_pass = ps; cp_cancel = lc;
    busy_cycles = 4'(w); xfer_words = 5'(n); core_stall = 0; ld_data = $urandom;
    cycle();
    cp_issue = 0; cp_pass = 1; cp_cancel = 0;
    for (int g = 0; g < 200 && m_st != 0; g++) begin
      core_stall = (int'($urandom % 100) < stall_pct);
      ld_data = $urandom;
      if ((hs_code == 2'b01 || hs_code == 2'b11) && !core_stall) moved++;
      cycle();
    end
    core_stall = 0;
    // R5 (clamped counts) and R4 (plain counts): words moved per transfer
    chk(moved == (acc ? words_for(n) : 0), (n == 0 || n > DEPTH) ? "R5" : "R4",
        "words moved", moved, acc ? words_for(n) : 0);
    cycle();
  endtask

  initial begin
    #1ms;
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) known[i] = 0;
    repeat (3) @(negedge clk);
    // R1: values under reset
    chk(hs_code == 2'b10, "R1", "hs in reset", hs_code, 2'b10);
    chk(st_own == 0, "R1", "own in reset", st_own, 0);
    chk(ld_done == 0, "R1", "done in reset", ld_done, 0);
    rst = 0;
    cycle();
    // R1: values in the first cycle after release
    chk(hs_code == 2'b10, "R1", "hs after reset", hs_code, 2'b10);

    // R9: full load, then read back through a store
    xact(1, MY_CP, 0, 16, 1, 0, 0);
    data_tag = "R9";
    xact(0, MY_CP, 2, 16, 1, 0, 0);
    data_tag = "R10";
    // R3: longest hold; R4: single word
    xact(1, MY_CP, 15, 1, 1, 0, 0);
    xact(0, MY_CP, 3, 1, 1, 0, 0);
    // R5: zero count and count above depth
    xact(1, MY_CP, 1, 0, 1, 0, 0);
    xact(0, MY_CP, 0, 20, 1, 0, 0);
    // R6: heavy stalls in hold and move cycles
    move_tag = "R6";
    xact(1, MY_CP, 5, 9, 1, 0, 60);
    xact(0, MY_CP, 4, 12, 1, 0, 60);
    move_tag = "R4";
    // R7: dropped loads must leave buffer untouched; R8: dropped store still owns bus
    none_tag = "R7";
    xact(1, MY_CP, 0, 16, 0, 0, 0);
    xact(1, MY_CP, 2, 16, 1, 1, 0);
    xact(0, MY_CP, 0, 4, 0, 0, 0);
    chk(st_own == 1, "R8", "own after dropped store", st_own, 1);
    none_tag = "R2";
    xact(0, MY_CP, 0, 16, 1, 0, 0);
    // R2: other coprocessor number
    xact(1, 4'd3, 0, 5, 1, 0, 0);
    chk(st_own == 0, "R8", "own after foreign issue", st_own, 0);

    for (int k = 0; k < 160; k++) begin
      logic [3:0] cp;
      int w;
      cp = ($urandom % 8 == 0) ? 4'(($urandom % 7) + 8) : MY_CP;
      w  = ($urandom % 4 == 0) ? int'($urandom % 16) : int'($urandom % 3);
      xact($urandom % 2, cp, w, int'($urandom % 20), ($urandom % 8) != 0,
           ($urandom % 10) == 0, 25);
      repeat ($urandom % 3) cycle();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule